// File: doc/BRIEF.md
# LCD raster timing generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the column and row of the current active pixel. It runs on the pixel clock and walks each line through sync, back porch, active and front porch segments. Each frame goes through the same four segments counted in lines. All lengths come from three 32-bit timing words that software loads through a small write port. A fourth word holds the enable and interrupt-mask bits, and a fifth address clears the frame event.

Each output strobe has its own polarity inversion bit. One more bit is passed out to select which pixel-clock edge launches pixel data. A one-cycle frame-start pulse sets a sticky status bit, and that bit, gated by a mask, drives the interrupt line. Timing words may be rewritten at any time. While the generator is stopped they are taken up at once. While it runs they are held back until the next frame begins, so a frame is never cut short.

Top module: `lcdt_raster_gen`

## Requirements
- R1: While disabled (including after reset) both counters sit at the start of sync, raw hsync/vsync/data-enable are low (the pins show only the polarity bits), pixX, pixY and frameTick are 0, and after reset irq is 0.
- R2: Register address 0 sets the line. Each line is, in order: sync of bits[15:8]+1 clocks, back porch of bits[31:24]+1 clocks, active of 16×(bits[7:2]+1) clocks, front porch of bits[23:16]+1 clocks. Raw hsync is high exactly during the sync clocks.
- R3: Register address 1 sets the frame. Each frame is, in order: sync of bits[15:10]+1 lines, back porch of bits[31:24] lines, active of bits[9:0]+1 lines, front porch of bits[23:16] lines. The porch counts may be zero. The line counter advances once per completed line, and raw vsync is high exactly during the sync lines.
- R4: Raw data-enable is high only where both the horizontal and the vertical position are in their active segments. There, pixX and pixY give the offset from the first active clock and the first active line. Elsewhere both are 0.
- R5: Register address 2 holds the polarity bits: bit0 inverts hsync, bit1 inverts vsync, bit2 inverts dataEn, and bit3 appears on pixEdgeSel. Bits [31:16] have no effect on any output.
- R6: A timing word written while running takes effect on the first cycle of the next frame. A word written while disabled is in use from the first cycle after enable.
- R7: Register address 3 has bit0 as enable and bit1 as interrupt mask. The first cycle after enable is set is line 0, clock 0. frameTick is high for exactly that one cycle at the start of every frame.
- R8: frameTick sets a status bit. Writing address 4 with bit0=1 clears it, and a tick in the same cycle wins over the clear. irq equals status AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| hSync | output | 1 | Horizontal sync after polarity |
| vSync | output | 1 | Vertical sync after polarity |
| dataEn | output | 1 | Data enable after polarity |
| pixX | output | COORD_W (10) | Active pixel column |
| pixY | output | COORD_W (10) | Active pixel row |
| pixEdgeSel | output | 1 | Pixel data launch edge select |
| frameTick | output | 1 | One-cycle frame start pulse |
| irq | output | 1 | Masked frame event interrupt |

## Verification
The assertions assume that writes use only addresses 0 to 4. They also rely on the counter width covering the longest line and frame the fields can code, so the counters stay within their segment limits. The timing-word shadow may change only while stopped or on the last cycle of a frame. The stimulus writes words either before enable or early in a frame that is much longer than the write sequence, and it drives the write port only on the falling edge. A scoreboard predicts every output for each clock of one frame under one setting and two frames under a second setting. The second setting is loaded mid-frame with junk in the ignored upper polarity bits.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [2:0] {
    ADDR_HORZ = 3'd0,
    ADDR_VERT = 3'd1,
    ADDR_POL  = 3'd2,
    ADDR_CTRL = 3'd3,
    ADDR_CLR  = 3'd4
  } regAddr_e;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic run;
    logic loadShadow;
  } ctlStrb_t;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        frameTick,
  input  logic        frameEnd,
  output logic [31:0] horzWord,
  output logic [31:0] vertWord,
  output logic [31:0] polWord,
  output ctlStrb_t    strb,
  output logic        irq
);

  logic enableQ;
  logic maskQ;
  logic statusQ;
  logic clrHit;

  assign clrHit = wrEn && (wrAddr == ADDR_CLR) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      horzWord <= '0;
      vertWord <= '0;
      polWord  <= '0;
      enableQ  <= 1'b0;
      maskQ    <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_HORZ: horzWord <= wrData;
        ADDR_VERT: vertWord <= wrData;
        ADDR_POL:  polWord  <= wrData;
        ADDR_CTRL: begin
          enableQ <= wrData[0];
          maskQ   <= wrData[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          statusQ <= 1'b0;
    else if (frameTick) statusQ <= 1'b1;
    else if (clrHit)    statusQ <= 1'b0;
  end

  always_comb begin
    strb.run        = enableQ;
    strb.loadShadow = !enableQ || frameEnd;
  end

  assign irq = statusQ && maskQ;

  // R8
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> $past(frameTick));

  // R8
  status_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && !frameTick) |=> !statusQ);

endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
  import lcdt_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic [31:0]        horzWord,
  input  logic [31:0]        vertWord,
  input  logic [31:0]        polWord,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               pixEdgeSel,
  output logic               frameTick,
  output logic               frameEnd
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam int NUM_POL = 3;

  // decoded segment boundaries from the staging words
  logic [CNT_W-1:0] nHSyncEnd, nHActStart, nHActEnd, nHLast;
  logic [CNT_W-1:0] nVSyncEnd, nVActStart, nVActEnd, nVLast;

  always_comb begin
    nHSyncEnd  = CNT_W'(horzWord[15:8]) + CNT_ONE;
    nHActStart = nHSyncEnd + CNT_W'(horzWord[31:24]) + CNT_ONE;
    nHActEnd   = nHActStart + ((CNT_W'(horzWord[7:2]) + CNT_ONE) << 4);
    nHLast     = nHActEnd + CNT_W'(horzWord[23:16]);
    nVSyncEnd  = CNT_W'(vertWord[15:10]) + CNT_ONE;
    nVActStart = nVSyncEnd + CNT_W'(vertWord[31:24]);
    nVActEnd   = nVActStart + CNT_W'(vertWord[9:0]) + CNT_ONE;
    nVLast     = nVActEnd + CNT_W'(vertWord[23:16]) - CNT_ONE;
  end

  // shadow copy used by the running raster
  logic [CNT_W-1:0] hSyncEndQ, hActStartQ, hActEndQ, hLastQ;
  logic [CNT_W-1:0] vSyncEndQ, vActStartQ, vActEndQ, vLastQ;
  logic [NUM_POL-1:0] invQ;
  logic               edgeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncEndQ  <= '0;
      hActStartQ <= '0;
      hActEndQ   <= '0;
      hLastQ     <= '0;
      vSyncEndQ  <= '0;
      vActStartQ <= '0;
      vActEndQ   <= '0;
      vLastQ     <= '0;
      invQ       <= '0;
      edgeQ      <= 1'b0;
    end else if (strb.loadShadow) begin
      hSyncEndQ  <= nHSyncEnd;
      hActStartQ <= nHActStart;
      hActEndQ   <= nHActEnd;
      hLastQ     <= nHLast;
      vSyncEndQ  <= nVSyncEnd;
      vActStartQ <= nVActStart;
      vActEndQ   <= nVActEnd;
      vLastQ     <= nVLast;
      invQ       <= polWord[NUM_POL-1:0];
      edgeQ      <= polWord[3];
    end
  end

  // raster counters
  logic [CNT_W-1:0] hCnt, vCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == hLastQ) begin
      hCnt <= '0;
      vCnt <= (vCnt == vLastQ) ? '0 : vCnt + CNT_ONE;
    end else begin
      hCnt <= hCnt + CNT_ONE;
    end
  end

  logic hSyncRaw, vSyncRaw, hAct, vAct, deRaw;

  always_comb begin
    hSyncRaw = strb.run && (hCnt < hSyncEndQ);
    vSyncRaw = strb.run && (vCnt < vSyncEndQ);
    hAct     = (hCnt >= hActStartQ) && (hCnt < hActEndQ);
    vAct     = (vCnt >= vActStartQ) && (vCnt < vActEndQ);
    deRaw    = strb.run && hAct && vAct;
  end

  assign pixX = deRaw ? COORD_W'(hCnt - hActStartQ) : '0;
  assign pixY = deRaw ? COORD_W'(vCnt - vActStartQ) : '0;

  logic [NUM_POL-1:0] rawSig, pinSig;
  assign rawSig = {deRaw, vSyncRaw, hSyncRaw};

  for (genvar i = 0; i < NUM_POL; i++) begin : g_pol
    assign pinSig[i] = rawSig[i] ^ invQ[i];
  end

  assign hSync      = pinSig[0];
  assign vSync      = pinSig[1];
  assign dataEn     = pinSig[2];
  assign pixEdgeSel = edgeQ;

  assign frameTick = strb.run && (hCnt == '0) && (vCnt == '0);
  assign frameEnd  = strb.run && (hCnt == hLastQ) && (vCnt == vLastQ);

  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (hCnt <= hLastQ));

  // R3
  vcnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && hCnt == hLastQ && vCnt != vLastQ) |=> (vCnt == $past(vCnt) + CNT_ONE));

  // R4
  de_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    deRaw |-> (!hSyncRaw && !vSyncRaw));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.loadShadow) |=> ($stable(hLastQ) && $stable(vLastQ) && $stable(invQ)));

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> !frameTick);

endmodule

// File: rtl/lcdt_raster_gen.sv
module lcdt_raster_gen
  import lcdt_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [31:0]        wrData,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               pixEdgeSel,
  output logic               frameTick,
  output logic               irq
);

  logic [31:0] horzWord, vertWord, polWord;
  ctlStrb_t    strb;
  logic        frameEnd;

  lcdt_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .frameTick (frameTick),
    .frameEnd  (frameEnd),
    .horzWord  (horzWord),
    .vertWord  (vertWord),
    .polWord   (polWord),
    .strb      (strb),
    .irq       (irq)
  );

  lcdt_timing #(
    .CNT_W   (CNT_W),
    .COORD_W (COORD_W)
  ) i_timing (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .horzWord   (horzWord),
    .vertWord   (vertWord),
    .polWord    (polWord),
    .hSync      (hSync),
    .vSync      (vSync),
    .dataEn     (dataEn),
    .pixX       (pixX),
    .pixY       (pixY),
    .pixEdgeSel (pixEdgeSel),
    .frameTick  (frameTick),
    .frameEnd   (frameEnd)
  );

endmodule

// File: tb/test_lcdt_raster_gen.sv
module test_lcdt_raster_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        hSync, vSync, dataEn, pixEdgeSel, frameTick, irq;
  logic [9:0]  pixX, pixY;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcdt_raster_gen i_lcdt_raster_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .pixX(pixX), .pixY(pixY),
    .pixEdgeSel(pixEdgeSel), .frameTick(frameTick), .irq(irq)
  );

  typedef struct {
    int hsw, hbp, ppl, hfp;
    int vsw, vbp, lpp, vfp;
    bit invH, invV, invD, edgeSel;
  } cfg_t;

  typedef struct {
    bit hs, vs, de, tick, irqv, edgeSel;
    int x, y;
    string tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    seenTick = 0;
  bit    maskOn = 1;

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: predicts every clock of a frame from the field values
  task automatic pushFrame(input cfg_t c, input string tg, input int limit);
    int hSyncLen = c.hsw + 1;
    int hBp      = c.hbp + 1;
    int hAct     = 16 * (c.ppl + 1);
    int hTot     = hSyncLen + hBp + hAct + c.hfp + 1;
    int vSyncLen = c.vsw + 1;
    int vAct     = c.lpp + 1;
    int vTot     = vSyncLen + c.vbp + vAct + c.vfp;
    int n = 0;
    for (int v = 0; v < vTot; v++) begin
      for (int h = 0; h < hTot; h++) begin
        item_t e;
        bit inH, inV;
        if (n < limit) begin
          inH = (h >= hSyncLen + hBp) && (h < hSyncLen + hBp + hAct);
          inV = (v >= vSyncLen + c.vbp) && (v < vSyncLen + c.vbp + vAct);
          e.hs = (h < hSyncLen) ^ c.invH;
          e.vs = (v < vSyncLen) ^ c.invV;
          e.de = (inH && inV) ^ c.invD;
          e.x  = (inH && inV) ? h - (hSyncLen + hBp) : 0;
          e.y  = (inH && inV) ? v - (vSyncLen + c.vbp) : 0;
          e.tick = (h == 0) && (v == 0);
          e.irqv = maskOn && seenTick;
          e.edgeSel = c.edgeSel;
          e.tag = tg;
          if (e.tick) seenTick = 1;
          expQ.push_back(e);
          n++;
        end
      end
    end
  endtask

  // monitor: compares outputs against queued predictions
  always @(negedge clk) begin
    item_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk({"R2", e.tag}, "hSync", int'(hSync), int'(e.hs));
      chk({"R3", e.tag}, "vSync", int'(vSync), int'(e.vs));
      chk({"R4", e.tag}, "dataEn", int'(dataEn), int'(e.de));
      chk({"R4", e.tag}, "pixX", int'(pixX), e.x);
      chk({"R4", e.tag}, "pixY", int'(pixY), e.y);
      chk({"R7", e.tag}, "frameTick", int'(frameTick), int'(e.tick));
      chk({"R8", e.tag}, "irq", int'(irq), int'(e.irqv));
      chk({"R5", e.tag}, "pixEdgeSel", int'(pixEdgeSel), int'(e.edgeSel));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  function automatic logic [31:0] horzOf(input cfg_t c);
    return 32'(c.ppl << 2) | 32'(c.hsw << 8) | 32'(c.hfp << 16) | 32'(c.hbp << 24);
  endfunction

  function automatic logic [31:0] vertOf(input cfg_t c);
    return 32'(c.lpp) | 32'(c.vsw << 10) | 32'(c.vfp << 16) | 32'(c.vbp << 24);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    cfg_t a, b;
    a = '{hsw:1, hbp:2, ppl:0, hfp:0, vsw:0, vbp:1, lpp:2, vfp:0,
          invH:0, invV:0, invD:0, edgeSel:0};
    b = '{hsw:0, hbp:0, ppl:1, hfp:2, vsw:1, vbp:0, lpp:1, vfp:2,
          invH:1, invV:0, invD:1, edgeSel:1};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "hSync", int'(hSync), 0);
    chk("R1", "vSync", int'(vSync), 0);
    chk("R1", "dataEn", int'(dataEn), 0);
    chk("R1", "pixX", int'(pixX), 0);
    chk("R1", "pixY", int'(pixY), 0);
    chk("R1", "frameTick", int'(frameTick), 0);
    chk("R1", "irq", int'(irq), 0);

    // config A loaded while stopped (R6), then enabled with mask (R7)
    wr(3'd0, horzOf(a));
    wr(3'd1, vertOf(a));
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h3);
    pushFrame(a, " R6", 1000000);
    pushFrame(b, " R5 R6", 1000000);
    pushFrame(b, " R5 R6", 10);

    // config B written mid-frame with junk in ignored polarity bits (R5, R6)
    repeat (5) @(posedge clk);
    wr(3'd0, horzOf(b));
    wr(3'd1, vertOf(b));
    wr(3'd2, 32'h0025_000D);

    wait (expQ.size() == 0);
    // stop with mask kept: idle levels follow polarity only (R1, R5)
    wr(3'd3, 32'h2);
    @(negedge clk);
    chk("R1 R5", "hSync idle", int'(hSync), 1);
    chk("R1", "vSync idle", int'(vSync), 0);
    chk("R1 R5", "dataEn idle", int'(dataEn), 1);
    chk("R1", "pixX idle", int'(pixX), 0);
    chk("R1", "pixY idle", int'(pixY), 0);
    chk("R1", "frameTick idle", int'(frameTick), 0);
    chk("R5", "pixEdgeSel", int'(pixEdgeSel), 1);
    chk("R8", "irq sticky", int'(irq), 1);

    // R8 clear
    wr(3'd4, 32'h1);
    @(negedge clk);
    chk("R8", "irq after clear", int'(irq), 0);

    // R8 masked: run without mask, status sets but irq stays low
    wr(3'd3, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8", "irq masked", int'(irq), 0);
    wr(3'd3, 32'h3);
    @(negedge clk);
    chk("R8", "irq unmasked", int'(irq), 1);

    finishRun();
  end

endmodule